// File: doc/BRIEF.md
# Cycle-Driven Interval Interrupt Timer

This block is a 16-bit down-counting interval timer that advances once for every processor cycle and drives a level-sensitive interrupt line. A bank controller already has a command/data register pair. The timer listens to that pair: a command number picks a timer register, and the data strobe writes a byte into it. Three command numbers belong to the timer. One is a control register, with separate enables for counting and for raising the interrupt. The other two load the low and high byte of the counter.

While counting is enabled, every cycle pulse lowers the counter by one. When a decrement lands on zero and the interrupt enable is set, the interrupt becomes pending and the output line stays high. A counter that is already at zero does not stop. On the next cycle it reloads to all ones and raises nothing. The only way to acknowledge a pending interrupt is a write to the control register. Writes to command numbers outside the timer's three are not the timer's business and change nothing.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset `irq_o` is 0, counting and the interrupt enable are off, and the counter holds 0xFFFF. So enabling both and giving 65535 cycle pulses raises `irq_o` on the last of them and not before.
- R2: A write with `cmd_i` = 13 sets the counting enable from `data_i` bit 7 and the interrupt enable from `data_i` bit 0.
- R3: A write with `cmd_i` = 14 replaces counter bits 7:0 with `data_i` and leaves bits 15:8 unchanged.
- R4: A write with `cmd_i` = 15 replaces counter bits 15:8 with `data_i` and leaves bits 7:0 unchanged.
- R5: With counting enabled, each `tick_i` cycle with a nonzero counter lowers it by exactly one. If that decrement gives 0 while the interrupt enable is set, `irq_o` goes high.
- R6: With counting enabled, a `tick_i` cycle on a counter of 0 reloads 0xFFFF and raises no interrupt.
- R7: Once `irq_o` is high, it stays high through further ticks and other writes. It drops only after a `cmd_i` = 13 write, whatever data that write carries.
- R8: With counting disabled, `tick_i` leaves the counter unchanged and no interrupt is raised.
- R9: With the interrupt enable off, reaching zero raises nothing, and the counter keeps decrementing.
- R10: A write to command 13, 14 or 15 in a cycle where `tick_i` is high takes priority: the decrement for that cycle is skipped.
- R11: `irq_o` is a register output. It rises at the clock edge where the counter reaches zero and falls at the edge that takes a control write, with no combinational path from `wr_i`.
- R12: Writes with `cmd_i` from 0 to 12 affect neither the counter, the enables nor `irq_o`, and they do not block a decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per processor cycle |
| wr_i | input | 1 | Data-port write strobe |
| cmd_i | input | 4 | Command number currently selected |
| data_i | input | 8 | Data byte of the write |
| irq_o | output | 1 | Interrupt line, active high, level |

## Verification
A decrement or a write that changes `irq_o` takes effect at the same rising edge that samples it. The expected level is therefore due one edge after the stimulus is driven, and a control write drops the line after exactly that one edge. The driver applies each stimulus on the falling edge and queues the level `irq_o` must show after the next rising edge. The monitor compares that level 5 ns after the edge, one queue entry per clock. Exact countdown lengths, such as 65535 pulses from reset or 255 after a reload, pin each rise to its cycle. A separate probe confirms that `irq_o` is still high after a control write has been driven but before the edge.

// File: rtl/cit_pkg.sv
package cit_pkg;

  // Operation chosen for the counter in one clock
  typedef enum logic [1:0] {
    CNT_IDLE = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_WRAP = 2'd3
  } cnt_op_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/cit_rst_sync.sv
module cit_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  localparam int unsigned N = (STAGES < cit_pkg::MIN_SYNC_STAGES) ?
                              cit_pkg::MIN_SYNC_STAGES : STAGES;

  logic [N-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[N-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[N-1];

endmodule

// File: rtl/cit_cmd_dec.sv
module cit_cmd_dec #(
  parameter int unsigned CMD_W      = 4,
  parameter int unsigned CTRL_CMD   = 13,
  parameter int unsigned LOAD_BASE  = 14,
  parameter int unsigned NUM_LANES  = 2
) (
  input  logic                 wr_i,
  input  logic [CMD_W-1:0]     cmd_i,
  output logic                 ctrl_wr_o,
  output logic [NUM_LANES-1:0] lane_wr_o,
  output logic                 any_wr_o
);

  assign ctrl_wr_o = wr_i && (cmd_i == CMD_W'(CTRL_CMD));

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_wr_o[g] = wr_i && (cmd_i == CMD_W'(LOAD_BASE + g));
  end

  assign any_wr_o = ctrl_wr_o || (|lane_wr_o);

endmodule

// File: rtl/cit_counter.sv
module cit_counter #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_LANES = 2,
  localparam int unsigned CNT_W    = DATA_W * NUM_LANES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 run_i,
  input  logic                 any_wr_i,
  input  logic [NUM_LANES-1:0] lane_wr_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 zero_hit_o
);

  import cit_pkg::*;

  cnt_op_e          op;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Any own-register write blocks the decrement of that cycle
  always_comb begin
    op = CNT_IDLE;
    if (|lane_wr_i) begin
      op = CNT_LOAD;
    end else if (!any_wr_i && tick_i && run_i) begin
      op = (cnt_q == '0) ? CNT_WRAP : CNT_DEC;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    unique case (op)
      CNT_LOAD: begin
        for (int l = 0; l < NUM_LANES; l++) begin
          if (lane_wr_i[l]) begin
            cnt_d[l*DATA_W +: DATA_W] = data_i;
          end
        end
      end
      CNT_DEC:  cnt_d = cnt_q - CNT_W'(1);
      CNT_WRAP: cnt_d = '1;
      default:  cnt_d = cnt_q;
    endcase
  end

  assign cnt_en = (op != CNT_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_hit_o = (op == CNT_DEC) && (cnt_q == CNT_W'(1));
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/cit_irq_ctrl.sv
module cit_irq_ctrl #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RUN_BIT = 7,
  parameter int unsigned ARM_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              zero_hit_i,
  output logic              run_o,
  output logic              arm_o,
  output logic              irq_o
);

  logic run_q, run_d;
  logic arm_q, arm_d;
  logic pend_q, pend_d;
  logic state_en;

  always_comb begin
    run_d  = run_q;
    arm_d  = arm_q;
    pend_d = pend_q;
    if (ctrl_wr_i) begin
      run_d  = data_i[RUN_BIT];
      arm_d  = data_i[ARM_BIT];
      pend_d = 1'b0;
    end else if (zero_hit_i && arm_q) begin
      pend_d = 1'b1;
    end
  end

  assign state_en = ctrl_wr_i || zero_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (state_en) begin
      run_q  <= run_d;
      arm_q  <= arm_d;
      pend_q <= pend_d;
    end
  end

  assign run_o = run_q;
  assign arm_o = arm_q;
  assign irq_o = pend_q;

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CMD_W      = 4,
  parameter int unsigned CNT_LANES  = 2,
  parameter int unsigned CTRL_CMD   = 13,
  parameter int unsigned LOAD_BASE  = 14,
  parameter int unsigned RUN_BIT    = 7,
  parameter int unsigned ARM_BIT    = 0,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              irq_o
);

  localparam int unsigned CNT_W = DATA_W * CNT_LANES;

  logic                 rst_sn;
  logic                 ctrl_wr;
  logic [CNT_LANES-1:0] lane_wr;
  logic                 any_wr;
  logic [CNT_W-1:0]     cnt_q;
  logic                 zero_hit;
  logic                 run_q;
  logic                 arm_q;

  cit_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sn)
  );

  cit_cmd_dec #(
    .CMD_W     (CMD_W),
    .CTRL_CMD  (CTRL_CMD),
    .LOAD_BASE (LOAD_BASE),
    .NUM_LANES (CNT_LANES)
  ) u_dec (
    .wr_i      (wr_i),
    .cmd_i     (cmd_i),
    .ctrl_wr_o (ctrl_wr),
    .lane_wr_o (lane_wr),
    .any_wr_o  (any_wr)
  );

  cit_counter #(
    .DATA_W    (DATA_W),
    .NUM_LANES (CNT_LANES)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .tick_i     (tick_i),
    .run_i      (run_q),
    .any_wr_i   (any_wr),
    .lane_wr_i  (lane_wr),
    .data_i     (data_i),
    .cnt_o      (cnt_q),
    .zero_hit_o (zero_hit)
  );

  cit_irq_ctrl #(
    .DATA_W  (DATA_W),
    .RUN_BIT (RUN_BIT),
    .ARM_BIT (ARM_BIT)
  ) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .ctrl_wr_i  (ctrl_wr),
    .data_i     (data_i),
    .zero_hit_i (zero_hit),
    .run_o      (run_q),
    .arm_o      (arm_q),
    .irq_o      (irq_o)
  );

endmodule

// File: rtl/cit_timer_chk.sv
module cit_timer_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CMD_W     = 4,
  parameter int unsigned CNT_LANES = 2,
  parameter int unsigned CTRL_CMD  = 13,
  parameter int unsigned LOAD_BASE = 14,
  localparam int unsigned CNT_W    = DATA_W * CNT_LANES
) (
  input logic              clk_i,
  input logic              rst_sn,
  input logic              tick_i,
  input logic              wr_i,
  input logic [CMD_W-1:0]  cmd_i,
  input logic [DATA_W-1:0] data_i,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              run_q,
  input logic              arm_q,
  input logic              irq_o
);

  logic ctrl_w;
  logic load_w;
  logic own_w;
  logic live_tick;

  assign ctrl_w    = wr_i && (cmd_i == CMD_W'(CTRL_CMD));
  assign load_w    = wr_i && (cmd_i >= CMD_W'(LOAD_BASE)) &&
                     ({1'b0, cmd_i} < (CMD_W+1)'(LOAD_BASE + CNT_LANES));
  assign own_w     = ctrl_w || load_w;
  assign live_tick = tick_i && run_q && !own_w;

  // R5: one step down per live tick on a nonzero count
  p_step_down_r5: assert property (@(posedge clk_i) disable iff (!rst_sn)
    live_tick && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R5: arriving at zero with the interrupt armed raises the line
  p_zero_raise_r5: assert property (@(posedge clk_i) disable iff (!rst_sn)
    live_tick && arm_q && (cnt_q == CNT_W'(1)) |=> irq_o);

  // R6: zero reloads all ones, line level unaffected
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_sn)
    live_tick && (cnt_q == '0) |=> (cnt_q == '1) && (irq_o == $past(irq_o)));

  // R7: a control write always acknowledges
  p_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_sn)
    ctrl_w |=> !irq_o);

  // R7: pending level holds until a control write
  p_hold_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_sn)
    irq_o && !ctrl_w |=> irq_o);

  // R8: stopped counter keeps its value unless loaded
  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !run_q && !load_w |=> $stable(cnt_q));

  // R9: disarmed timer never raises the line
  p_disarmed_r9: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !arm_q && !irq_o |=> !irq_o);

  // R10: a control write in a tick cycle leaves the count alone
  p_ctrl_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_sn)
    ctrl_w |=> $stable(cnt_q));

  // R3 (lane 0) and R4 (lane 1): byte replaced, other bytes kept
  for (genvar g = 0; g < CNT_LANES; g++) begin : g_lane_chk
    localparam logic [CNT_W-1:0] LANE_MASK = {{(CNT_W-DATA_W){1'b0}}, {DATA_W{1'b1}}} << (g*DATA_W);
    p_lane_load_r3: assert property (@(posedge clk_i) disable iff (!rst_sn)
      wr_i && (cmd_i == CMD_W'(LOAD_BASE + g)) |=>
        (cnt_q[g*DATA_W +: DATA_W] == $past(data_i)) &&
        ((cnt_q & ~LANE_MASK) == ($past(cnt_q) & ~LANE_MASK)));
  end

endmodule

bind cyc_irq_timer cit_timer_chk #(
  .DATA_W    (DATA_W),
  .CMD_W     (CMD_W),
  .CNT_LANES (CNT_LANES),
  .CTRL_CMD  (CTRL_CMD),
  .LOAD_BASE (LOAD_BASE)
) u_chk (
  .clk_i  (clk_i),
  .rst_sn (rst_sn),
  .tick_i (tick_i),
  .wr_i   (wr_i),
  .cmd_i  (cmd_i),
  .data_i (data_i),
  .cnt_q  (cnt_q),
  .run_q  (run_q),
  .arm_q  (arm_q),
  .irq_o  (irq_o)
);

// File: tb/tb_cyc_irq_timer.sv
`timescale 1ns/1ps
module tb_cyc_irq_timer;

  localparam int unsigned WD_CYCLES = 199000;
  localparam logic [3:0]  C_CTRL = 4'd13;
  localparam logic [3:0]  C_LO   = 4'd14;
  localparam logic [3:0]  C_HI   = 4'd15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr;
  logic [3:0] cmd;
  logic [7:0] data;
  logic       irq;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  cyc_irq_timer dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .tick_i (tick),
    .wr_i   (wr),
    .cmd_i  (cmd),
    .data_i (data),
    .irq_o  (irq)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, queue the level due after the edge
  task automatic step(input logic tk, input logic w, input logic [3:0] c,
                      input logic [7:0] d, input bit e, input string tag);
    @(negedge clk);
    tick = tk; wr = w; cmd = c; data = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run(input int n, input bit e, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 4'd0, 8'h00, e, tag);
  endtask

  task automatic put(input logic [3:0] c, input logic [7:0] d, input bit e, input string tag);
    step(1'b0, 1'b1, c, d, e, tag);
  endtask

  // monitor: compare once per clock, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(irq, e, t);
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr = 1'b0; cmd = 4'd0; data = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(irq, 1'b0, "R1 irq low in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(irq, 1'b0, "R1 irq low after reset");

    // R1: counter starts at 0xFFFF
    put(C_CTRL, 8'h81, 1'b0, "R2 enable both");
    run(65534, 1'b0, "R1 no early irq from 0xFFFF");
    run(1, 1'b1, "R1 irq after 65535 ticks");
    put(C_CTRL, 8'h00, 1'b0, "R7 ack clears");

    // R5, R7, R12
    put(C_HI, 8'h00, 1'b0, "R4 load high");
    put(C_LO, 8'h05, 1'b0, "R3 load low");
    put(C_CTRL, 8'h81, 1'b0, "R2 enable both");
    run(4, 1'b0, "R5 count down from 5");
    run(1, 1'b1, "R5 irq at zero");
    run(4, 1'b1, "R7 pending held through ticks");
    put(4'd5, 8'h00, 1'b1, "R12 foreign command keeps irq");
    // R11: level must not react before the edge
    @(negedge clk);
    tick = 1'b0; wr = 1'b1; cmd = C_CTRL; data = 8'h81;
    exp_q.push_back(1'b0); tag_q.push_back("R7 ack after edge");
    #2;
    check(irq, 1'b1, "R11 no combinational drop on write");

    // counter now 0xFFFC; R4 keeps low byte
    put(C_HI, 8'h00, 1'b0, "R4 high byte write");
    run(251, 1'b0, "R4 low byte kept (0x00FC)");
    run(1, 1'b1, "R4 irq after 252 ticks");
    put(C_CTRL, 8'h00, 1'b0, "R7 ack");
    put(C_HI, 8'h01, 1'b0, "R4 load high");
    put(C_LO, 8'h02, 1'b0, "R3 low byte write keeps high");
    put(C_CTRL, 8'h81, 1'b0, "R2 enable both");
    run(257, 1'b0, "R3 high byte kept (0x0102)");
    run(1, 1'b1, "R3 irq after 258 ticks");
    put(C_CTRL, 8'h01, 1'b0, "R2 counting off, irq armed");

    // R8
    put(C_LO, 8'h03, 1'b0, "R3 load 3");
    run(10, 1'b0, "R8 held while stopped");
    put(C_CTRL, 8'h81, 1'b0, "R2 start counting");
    run(2, 1'b0, "R8 value 3 was held");
    run(1, 1'b1, "R8 irq after 3 ticks");
    put(C_CTRL, 8'h80, 1'b0, "R2 count only");

    // R9
    put(C_LO, 8'h02, 1'b0, "R3 load 2");
    run(2, 1'b0, "R9 zero reached disarmed");
    run(1, 1'b0, "R9 wrap disarmed");
    put(C_HI, 8'h00, 1'b0, "R4 load high");
    put(C_LO, 8'h05, 1'b0, "R3 load low");
    run(3, 1'b0, "R9 counting while disarmed");
    put(C_CTRL, 8'h81, 1'b0, "R2 arm");
    run(1, 1'b0, "R9 count continued");
    run(1, 1'b1, "R9 irq after 5 total ticks");
    put(C_CTRL, 8'h81, 1'b0, "R7 ack");

    // R6: counter 0 -> 0xFFFF, no irq
    run(1, 1'b0, "R6 wrap raises nothing");
    put(C_HI, 8'h00, 1'b0, "R4 high zero");
    run(254, 1'b0, "R6 low byte is 0xFF after wrap");
    run(1, 1'b1, "R6 irq after 255 ticks");
    put(C_CTRL, 8'h81, 1'b0, "R7 ack");

    // R10: write wins over tick
    step(1'b1, 1'b1, C_LO, 8'h03, 1'b0, "R10 load with tick");
    run(2, 1'b0, "R10 load not decremented");
    run(1, 1'b1, "R10 irq after 3 ticks");
    put(C_LO, 8'h03, 1'b1, "R7 load keeps irq");
    step(1'b1, 1'b1, C_CTRL, 8'h81, 1'b0, "R10 ctrl with tick");
    run(2, 1'b0, "R10 ctrl write skipped decrement");
    run(1, 1'b1, "R10 irq after 3 more ticks");
    put(C_CTRL, 8'h81, 1'b0, "R7 ack");

    // R12: foreign command does not block a tick
    put(C_LO, 8'h03, 1'b0, "R3 load 3");
    step(1'b1, 1'b1, 4'd12, 8'hFF, 1'b0, "R12 tick with foreign write");
    run(1, 1'b0, "R12 count continued");
    run(1, 1'b1, "R12 irq after 3 ticks");
    put(4'd0, 8'h00, 1'b1, "R12 foreign write keeps irq");
    put(C_CTRL, 8'h00, 1'b0, "R7 ack");
    step(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, "R11 idle low");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule